// File: doc/BRIEF.md
# Configuration Memory Word Fetch Registers

This block gives a host access to a 1024-byte configuration memory that is organised as 16-bit words. One 32-bit access register carries everything for a read. The host writes an address into it. Clearing the command bit in the same register starts the read. A flag in that register then reports completion, and the fetched word appears in its upper half. Between the start of a read and the flag, the host polls the register; the polling interval and the timeout belong to the host.

Two agents can use the memory: the host and an internal agent. An ownership bit in a hardware-config register decides which of them holds it, and only the owner-holding host may start reads. A general-purpose status register tells whether word 0 of the memory holds the expected signature.

The memory is a behavioural array with a fixed read latency, set in clock cycles by a parameter. A preload port fills the array with an initial image before use.

Top module: `cfgrom_rd_regs`

## Requirements
- R1: After reset, the access register (select 1) reads 0, the hardware-config register (select 0) reads 0, and `agent_grant` is low.
- R2: Writing the hardware-config register with bit 21 set takes host ownership when the internal agent does not hold it, and bit 21 then reads back 1. Writing it with bit 21 clear releases ownership, and bit 21 then reads back 0.
- R3: When the host does not own the memory, `agent_req` raises `agent_grant` one cycle later. A host claim made while the agent holds the memory is refused. When the host claims in the same cycle as a fresh agent request, the host wins. Dropping `agent_req` drops `agent_grant` one cycle later. Host and agent never hold the memory at the same time.
- R4: The access register value is the byte address shifted left by one, so the word index sits in bits 10:2. A write with bit 1 (the command bit) clear, made while the host owns the memory, starts a read of that word. A write with bit 1 set stores the address and the command bit, which read back in bits 10:2 and bit 1, and starts no read.
- R5: Bit 0 (valid) of the access register rises exactly RD_LAT cycles after the starting write. From then on, bits 31:16 hold the addressed word. Valid and the data stay unchanged until the next write to the access register.
- R6: Any write to the access register clears valid in the next cycle. Valid then stays low until the word requested by a new read is available.
- R7: A read request made while the host does not own the memory is ignored. Valid stays low and bits 31:16 keep their previous value.
- R8: Bits 2:1 of the status register (select 2) read 2'b11 when memory word 0 equals SIG_WORD and 2'b00 (bad signature) otherwise. All other bits read 0. The field follows a preload of word 0 within two cycles.
- R9: A new read started while one is in progress cancels the earlier one. Only the later word is returned, RD_LAT cycles after the later write.
- R10: Every word index from 0 to 511 can be read, including both ends of the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 2 | Register select: 0 hardware-config, 1 access, 2 status |
| reg_wr | input | 1 | Register write strobe for the selected register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| agent_req | input | 1 | Internal agent asks for the memory |
| agent_grant | output | 1 | Internal agent holds the memory |
| pre_we | input | 1 | Preload write enable for the memory array |
| pre_addr | input | 9 | Preload word index |
| pre_data | input | 16 | Preload word |

## Verification
A table of word indices is read back: the first words, the two words on either side of the 256 boundary, a middle word and the last two words. Each word holds a distinct computed value, so a dropped or swapped address bit returns a wrong value. Each index is first written with the command bit set, to show that storing an address starts nothing. The command bit is then cleared with a read-modify-write, and valid is sampled one cycle before and exactly at the expected latency, which separates an off-by-one counter from a correct one. Directed cases cover a request made without ownership, a restart during a read (to tell cancellation from a stale completion), the three ownership contests, and a good and a bad signature in word 0.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;

  typedef enum logic [1:0] {
    SEL_HWCFG  = 2'd0,
    SEL_ACCESS = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int OWN_BIT   = 21;
  localparam int CMD_BIT   = 1;
  localparam int VALID_BIT = 0;
  localparam int DATA_LSB  = 16;
  localparam int ADDR_LSB  = 2;

endpackage

// File: rtl/cfgrom_array.sv
module cfgrom_array #(
  parameter int WORDS = 512,
  localparam int WA_W = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [WA_W-1:0] waddr,
  input  logic [15:0]     wdata,
  input  logic [WA_W-1:0] raddr,
  output logic [15:0]     rdata,
  output logic [15:0]     word0
);

  logic [15:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
  assign word0 = mem[0];

endmodule

// File: rtl/cfgrom_own_sem.sv
module cfgrom_own_sem (
  input  logic clk,
  input  logic rst_n,
  input  logic host_wr,
  input  logic host_claim,
  input  logic agent_req,
  output logic host_own,
  output logic agent_own
);

  logic host_q, host_d;
  logic agent_q, agent_d;

  always_comb begin
    host_d  = host_q;
    agent_d = agent_q;
    if (host_wr) begin
      if (!host_claim) begin
        host_d = 1'b0;
      end else if (!agent_q) begin
        host_d = 1'b1;
      end
    end
    if (!agent_req) begin
      agent_d = 1'b0;
    end else if (!agent_q && !host_q && !(host_wr && host_claim)) begin
      agent_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q  <= 1'b0;
      agent_q <= 1'b0;
    end else begin
      host_q  <= host_d;
      agent_q <= agent_d;
    end
  end

  assign host_own  = host_q;
  assign agent_own = agent_q;

  // R3
  excl_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_q && agent_q));

  // R2
  own_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_q && !(host_wr && !host_claim)) |=> host_q);

endmodule

// File: rtl/cfgrom_rd_seq.sv
module cfgrom_rd_seq #(
  parameter int RD_LAT = 8,
  parameter int WA_W   = 9,
  localparam int CW    = $clog2(RD_LAT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            abort_i,
  input  logic [WA_W-1:0] addr_i,
  output logic            busy_o,
  output logic            fire_o,
  output logic [WA_W-1:0] idx_o
);

  logic            busy_q, busy_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [WA_W-1:0] idx_q, idx_d;
  logic            fire;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    fire   = 1'b0;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CW'(RD_LAT - 1);
      idx_d  = addr_i;
    end else if (abort_i) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        fire   = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
    end
  end

  assign busy_o = busy_q;
  assign fire_o = fire;
  assign idx_o  = idx_q;

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(cnt_q) < RD_LAT));

endmodule

// File: rtl/cfgrom_rd_regs.sv
module cfgrom_rd_regs
  import cfgrom_pkg::*;
#(
  parameter int          MEM_BYTES = 1024,
  parameter int          RD_LAT    = 8,
  parameter logic [15:0] SIG_WORD  = 16'hA55A,
  localparam int         WORDS     = MEM_BYTES / 2,
  localparam int         WA_W      = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      reg_sel,
  input  logic            reg_wr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            agent_req,
  output logic            agent_grant,
  input  logic            pre_we,
  input  logic [WA_W-1:0] pre_addr,
  input  logic [15:0]     pre_data
);

  // reset: asynchronous assert, synchronous release
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  reg_sel_e sel;
  logic     acc_wr, cfg_wr, rd_start;
  logic     host_own, agent_own;
  logic     seq_busy, seq_fire;
  logic [WA_W-1:0] seq_idx;
  logic [15:0]     mem_rd, mem_w0;
  logic            wdata_unused;

  assign sel      = reg_sel_e'(reg_sel);
  assign acc_wr   = reg_wr && (sel == SEL_ACCESS);
  assign cfg_wr   = reg_wr && (sel == SEL_HWCFG);
  assign rd_start = acc_wr && !reg_wdata[CMD_BIT] && host_own;
  assign wdata_unused = ^{reg_wdata[31:OWN_BIT+1], reg_wdata[OWN_BIT-1:WA_W+ADDR_LSB],
                          reg_wdata[VALID_BIT]};

  cfgrom_own_sem u_sem (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .host_wr    (cfg_wr),
    .host_claim (reg_wdata[OWN_BIT]),
    .agent_req  (agent_req),
    .host_own   (host_own),
    .agent_own  (agent_own)
  );

  cfgrom_rd_seq #(.RD_LAT(RD_LAT), .WA_W(WA_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .start_i (rd_start),
    .abort_i (acc_wr),
    .addr_i  (reg_wdata[WA_W+ADDR_LSB-1:ADDR_LSB]),
    .busy_o  (seq_busy),
    .fire_o  (seq_fire),
    .idx_o   (seq_idx)
  );

  cfgrom_array #(.WORDS(WORDS)) u_mem (
    .clk   (clk),
    .we    (pre_we),
    .waddr (pre_addr),
    .wdata (pre_data),
    .raddr (seq_idx),
    .rdata (mem_rd),
    .word0 (mem_w0)
  );

  // access register state
  logic [WA_W-1:0] addr_q, addr_d;
  logic            cmd_q, cmd_d;
  logic            valid_q, valid_d;
  logic [15:0]     data_q, data_d;
  logic            sig_q, sig_d;

  always_comb begin
    addr_d  = addr_q;
    cmd_d   = cmd_q;
    valid_d = valid_q;
    data_d  = data_q;
    sig_d   = (mem_w0 == SIG_WORD);
    if (acc_wr) begin
      addr_d  = reg_wdata[WA_W+ADDR_LSB-1:ADDR_LSB];
      cmd_d   = reg_wdata[CMD_BIT];
      valid_d = 1'b0;
    end else if (seq_fire) begin
      valid_d = 1'b1;
      data_d  = mem_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      addr_q  <= '0;
      cmd_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      sig_q   <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      cmd_q   <= cmd_d;
      valid_q <= valid_d;
      data_q  <= data_d;
      sig_q   <= sig_d;
    end
  end

  // register read view
  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_HWCFG: reg_rdata[OWN_BIT] = host_own;
      SEL_ACCESS: begin
        reg_rdata[31:DATA_LSB]                = data_q;
        reg_rdata[WA_W+ADDR_LSB-1:ADDR_LSB]   = addr_q;
        reg_rdata[CMD_BIT]                    = cmd_q;
        reg_rdata[VALID_BIT]                  = valid_q;
      end
      SEL_STATUS: reg_rdata[2:1] = {sig_q, sig_q};
      default:    reg_rdata = '0;
    endcase
  end

  assign agent_grant = agent_own;

  // R6
  wr_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    acc_wr |=> !valid_q);

  // R7
  no_owner_ignore_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    (acc_wr && !reg_wdata[CMD_BIT] && !host_own) |=> (!seq_busy && $stable(data_q)));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    (valid_q && !acc_wr) |=> (valid_q && $stable(data_q)));

  // R4
  cmd_set_idle_chk: assert property (@(posedge clk) disable iff (!rst_s_q)
    (acc_wr && reg_wdata[CMD_BIT]) |=> !seq_busy);

endmodule

// File: tb/test_cfgrom_rd_regs.sv
`timescale 1ns/1ps
module test_cfgrom_rd_regs;

  localparam int          RD_LAT = 8;
  localparam logic [15:0] SIG    = 16'hA55A;
  localparam int          NVEC   = 8;
  localparam int          VEC_IDX [NVEC] = '{0, 1, 2, 255, 256, 300, 510, 511};

  localparam logic [1:0] S_CFG = 2'd0;
  localparam logic [1:0] S_ACC = 2'd1;
  localparam logic [1:0] S_STA = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_sel;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        agent_req;
  logic        agent_grant;
  logic        pre_we;
  logic [8:0]  pre_addr;
  logic [15:0] pre_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cfgrom_rd_regs #(.RD_LAT(RD_LAT), .SIG_WORD(SIG)) i_cfgrom_rd_regs (
    .clk, .rst_n, .reg_sel, .reg_wr, .reg_wdata, .reg_rdata,
    .agent_req, .agent_grant, .pre_we, .pre_addr, .pre_data
  );

  function automatic logic [15:0] pat(input int i);
    logic [31:0] t;
    if (i == 0) return SIG;
    t = i * 32'd40503;
    return t[15:0] ^ 16'h1234;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    reg_sel = s;
    #1;
    d = reg_rdata;
  endtask

  task automatic preload(input int i, input logic [15:0] w);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = 9'(i); pre_data = w;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  // start a read of idx by read-modify-write; returns right after the write edge
  task automatic start_rmw(input int idx);
    logic [31:0] v;
    wr(S_ACC, (32'(idx) << 2) | 32'h2);
    rd(S_ACC, v);
    wr(S_ACC, v & ~32'h2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int          n;
    rst_n = 1'b0; reg_sel = S_CFG; reg_wr = 1'b0; reg_wdata = '0;
    agent_req = 1'b0; pre_we = 1'b0; pre_addr = '0; pre_data = '0;
    waitn(3);
    rst_n = 1'b1;
    waitn(3);

    // R1 reset state
    rd(S_ACC, v); chk(v, 32'h0, "R1 access reg after reset");
    rd(S_CFG, v); chk(v, 32'h0, "R1 hwcfg reg after reset");
    chk(32'(agent_grant), 32'h0, "R1 agent_grant after reset");

    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      pre_we = 1'b1; pre_addr = 9'(i); pre_data = pat(i);
    end
    @(negedge clk);
    pre_we = 1'b0;
    waitn(2);

    // R8 good signature
    rd(S_STA, v); chk(v, 32'h6, "R8 status with good signature");

    // R7 read without ownership is ignored
    wr(S_ACC, 32'(5) << 2);
    waitn(RD_LAT + 2);
    rd(S_ACC, v);
    chk({31'h0, v[0]}, 32'h0, "R7 valid stays low without ownership");
    chk({16'h0, v[31:16]}, 32'h0, "R7 data unchanged without ownership");

    // R2 host takes ownership
    wr(S_CFG, 32'h1 << 21);
    rd(S_CFG, v); chk(v, 32'h0020_0000, "R2 host claim reads back");

    // table of indices
    for (int k = 0; k < NVEC; k++) begin
      wr(S_ACC, (32'(VEC_IDX[k]) << 2) | 32'h2);
      rd(S_ACC, v);
      chk({31'h0, v[1]}, 32'h1, "R4 command bit reads back set");
      chk({23'h0, v[10:2]}, 32'(VEC_IDX[k]), "R4 address field reads back");
      waitn(RD_LAT + 1);
      rd(S_ACC, v);
      chk({31'h0, v[0]}, 32'h0, "R4 no read while command bit set");
      start_rmw(VEC_IDX[k]);
      waitn(RD_LAT - 1);
      rd(S_ACC, v);
      chk({31'h0, v[0]}, 32'h0, "R5 valid not before latency");
      waitn(1);
      rd(S_ACC, v);
      chk({31'h0, v[0]}, 32'h1, "R5 valid at latency");
      chk({16'h0, v[31:16]}, {16'h0, pat(VEC_IDX[k])}, "R10 word data");
    end

    // R5 data holds while no write
    waitn(5);
    rd(S_ACC, v);
    chk({v[31:16], 15'h0, v[0]}, {pat(511), 16'h1}, "R5 data and valid hold");

    // R6 new address clears valid, then polled completion
    wr(S_ACC, 32'(77) << 2);
    rd(S_ACC, v);
    chk({31'h0, v[0]}, 32'h0, "R6 valid cleared by new address");
    n = 0;
    rd(S_ACC, v);
    while (!v[0] && n < 5000) begin
      waitn(1);
      n++;
      rd(S_ACC, v);
    end
    chk({16'h0, v[31:16]}, {16'h0, pat(77)}, "R6 polled word after new address");

    // R9 restart during a read
    wr(S_ACC, 32'(100) << 2);
    waitn(2);
    wr(S_ACC, 32'(400) << 2);
    waitn(RD_LAT - 1);
    rd(S_ACC, v);
    chk({31'h0, v[0]}, 32'h0, "R9 earlier read cancelled");
    waitn(1);
    rd(S_ACC, v);
    chk({v[31:16], 15'h0, v[0]}, {pat(400), 16'h1}, "R9 later word returned");

    // R3 arbitration
    wr(S_CFG, 32'h0);
    rd(S_CFG, v); chk(v, 32'h0, "R2 host release reads back");
    @(negedge clk); agent_req = 1'b1;
    @(negedge clk);
    chk(32'(agent_grant), 32'h1, "R3 agent granted when host idle");
    wr(S_CFG, 32'h1 << 21);
    rd(S_CFG, v); chk(v, 32'h0, "R3 host claim refused while agent holds");
    agent_req = 1'b0;
    @(negedge clk);
    chk(32'(agent_grant), 32'h0, "R3 agent grant drops");
    @(negedge clk);
    agent_req = 1'b1; reg_sel = S_CFG; reg_wdata = 32'h1 << 21; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(S_CFG, v); chk(v, 32'h0020_0000, "R3 host wins simultaneous claim");
    chk(32'(agent_grant), 32'h0, "R3 agent refused on simultaneous claim");
    agent_req = 1'b0;

    // R8 bad signature, then restore
    preload(0, 16'h0000);
    waitn(2);
    rd(S_STA, v); chk(v, 32'h0, "R8 status with bad signature");
    preload(0, SIG);
    waitn(2);
    rd(S_STA, v); chk(v, 32'h6, "R8 status restored");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule